// File: doc/BRIEF.md
# Clock-Slaved Synchronous Serial Receiver

This block receives 8-bit or 9-bit words over a half-duplex synchronous link. An external master drives the shift clock. The block only listens to that clock and never drives it. The clock and the data line are first brought into the system clock domain. Each bit is then taken on a falling edge of the external clock, least significant bit first. A completed word moves into a holding register, and the block raises a receive-ready flag. If the interrupt enable is set, it also raises a level interrupt request. Because the clock comes from outside, a word can finish while the host is idle, and the interrupt request can then act as a wake-up event.

Reception runs only when all of these hold: the port is enabled, synchronous mode is selected, the clock-source select is set to external, and the continuous-receive enable is high. The single-word receive control does nothing in this mode. An overrun is flagged when a word completes while the holding register is still unread. The overrun blocks further transfers until it is cleared by dropping the continuous-receive enable.

Top module: `ssr_slave_rx`

## Requirements
- R1: When `cfg_clk_master` is 1 (internal clock source), no word is received, whatever clock and data appear on the pins.
- R2: Reception takes place only while `cfg_cont_rx` is 1. `cfg_single_rx` has no effect: with `cfg_cont_rx` at 0 and `cfg_single_rx` at 1, nothing is received.
- R3: Bits are taken on falling edges of `sck_in`, least significant bit first. The first bit of a word lands in `rx_data[0]`.
- R4: Once the last bit of a word has been taken, the word appears on `rx_data` and `rx_ready` goes to 1, within 8 system clocks of the falling edge.
- R5: `rx_irq` is 1 exactly when `rx_ready` is 1 and `cfg_irq_en` is 1.
- R6: With `cfg_nine_bit` at 1, a word is 9 bits long and its ninth bit is reported on `rx_bit9`. With `cfg_nine_bit` at 0, a word is 8 bits long and `rx_bit9` reads 0.
- R7: Nothing is received unless both `cfg_sync_en` and `cfg_port_en` are 1.
- R8: If a word completes while `rx_ready` is still 1 and no read is made, `rx_overrun` goes to 1 and the new word is discarded, so `rx_data` keeps the old word. While `rx_overrun` is 1, later words are also discarded.
- R9: Setting `cfg_cont_rx` to 0 clears `rx_overrun`. Reception resumes once `cfg_cont_rx` is set to 1 again.
- R10: A one-cycle pulse on `rd_strobe` clears `rx_ready` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sync_en | input | 1 | Synchronous mode select |
| cfg_port_en | input | 1 | Serial port enable |
| cfg_clk_master | input | 1 | Clock source select, 0 = external clock |
| cfg_cont_rx | input | 1 | Continuous receive enable, also clears errors when 0 |
| cfg_single_rx | input | 1 | Single-word receive control, ignored with external clock |
| cfg_nine_bit | input | 1 | 9-bit word mode |
| cfg_irq_en | input | 1 | Receive interrupt enable |
| sck_in | input | 1 | External shift clock, idles high |
| sdat_in | input | 1 | Serial data line |
| rd_strobe | input | 1 | Read pulse for the holding register |
| rx_data | output | 8 | Received word, low 8 bits |
| rx_bit9 | output | 1 | Ninth received bit |
| rx_ready | output | 1 | Holding register has an unread word |
| rx_overrun | output | 1 | Overrun error flag |
| rx_irq | output | 1 | Receive interrupt / wake request |

## Verification
Suppose the bit counter drifts by even one position. Then every later word shows up at the ports rotated or split across two words. Because bits arrive LSB first, this is visible on `rx_data` as soon as the first wrong word is read. The scoreboard reports it at that first read. A stuck overrun or ready flag is different: it shows only when the next word is offered. After that word, either `rx_ready` does not rise or the data does not change. So the bench offers fresh words after every error-clear and read, and checks the flags within a dozen clocks of each word's last edge. A wrong gate on the enable terms produces an unexpected `rx_ready` during the idle-mode tests. That also shows up as an unexpected pop from the scoreboard.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int WORD_W    = 8;
    localparam int MAX_BITS  = WORD_W + 1;
    localparam int CNT_W     = $clog2(MAX_BITS + 1);

    typedef struct packed {
        logic              bit9;
        logic [WORD_W-1:0] data;
    } rx_word_t;

    typedef struct packed {
        logic sync_en;
        logic port_en;
        logic clk_master;
        logic cont_rx;
        logic single_rx;
        logic nine_bit;
        logic irq_en;
    } rx_cfg_t;

    // Receive armed: single-word control only matters with an internal clock.
    function automatic logic rx_armed(input rx_cfg_t c);
        return c.cont_rx | (c.single_rx & c.clk_master);
    endfunction

    // Block runs only in synchronous, enabled, externally clocked mode.
    function automatic logic rx_running(input rx_cfg_t c);
        return c.sync_en & c.port_en & ~c.clk_master & rx_armed(c);
    endfunction

    function automatic logic [CNT_W-1:0] last_index(input logic nine);
        return nine ? CNT_W'(MAX_BITS - 1) : CNT_W'(WORD_W - 1);
    endfunction

endpackage

// File: rtl/ssr_edge_sync.sv
module ssr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_raw,
    input  logic dat_raw,
    output logic sck_fall,
    output logic dat_sync
);
    localparam int SCK_LEN = STAGES + 1;

    logic [SCK_LEN-1:0] sck_q;
    logic [STAGES-1:0]  dat_q;

    generate
        for (genvar i = 0; i < SCK_LEN; i++) begin : g_sck
            always_ff @(posedge clk) begin
                if (rst)
                    sck_q[i] <= 1'b1;
                else if (i == 0)
                    sck_q[i] <= sck_raw;
                else
                    sck_q[i] <= sck_q[(i == 0) ? 0 : i-1];
            end
        end
        for (genvar j = 0; j < STAGES; j++) begin : g_dat
            always_ff @(posedge clk) begin
                if (rst)
                    dat_q[j] <= 1'b0;
                else if (j == 0)
                    dat_q[j] <= dat_raw;
                else
                    dat_q[j] <= dat_q[(j == 0) ? 0 : j-1];
            end
        end
    endgenerate

    assign sck_fall = sck_q[SCK_LEN-1] & ~sck_q[SCK_LEN-2];
    assign dat_sync = dat_q[STAGES-1];

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sck_fall |=> !sck_fall); // R3

endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
    import ssr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     nine_bit,
    input  logic     bit_stb,
    input  logic     bit_val,
    output logic     word_done,
    output rx_word_t word_out
);
    logic [MAX_BITS-1:0] shreg;
    logic [MAX_BITS-1:0] shreg_nx;
    logic [CNT_W-1:0]    cnt;
    logic                at_last;

    always_comb begin
        shreg_nx      = shreg;
        shreg_nx[cnt] = bit_val;
    end

    assign at_last = (cnt == last_index(nine_bit));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt       <= '0;
            word_done <= 1'b0;
            shreg     <= '0;
            word_out  <= '0;
        end else begin
            word_done <= 1'b0;
            if (bit_stb) begin
                shreg <= shreg_nx;
                if (at_last) begin
                    cnt           <= '0;
                    word_done     <= 1'b1;
                    word_out.data <= shreg_nx[WORD_W-1:0];
                    word_out.bit9 <= nine_bit & shreg_nx[MAX_BITS-1];
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_BITS - 1)); // R6
    AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (rst)
        !run |=> !word_done); // R2
    AST_DONE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        word_done |-> $past(bit_stb)); // R3

endmodule

// File: rtl/ssr_holding.sv
module ssr_holding
    import ssr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     irq_en,
    input  logic     word_done,
    input  rx_word_t word_in,
    input  logic     rd,
    output rx_word_t hold,
    output logic     ready,
    output logic     overrun,
    output logic     irq
);
    logic accept;
    logic collide;

    assign accept  = word_done & ~overrun & (~ready | rd);
    assign collide = word_done & ready & ~rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= '0;
            ready <= 1'b0;
        end else if (accept) begin
            hold  <= word_in;
            ready <= 1'b1;
        end else if (rd) begin
            ready <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run)
            overrun <= 1'b0;
        else if (collide)
            overrun <= 1'b1;
    end

    assign irq = ready & irq_en;

    AST_READY_AFTER_WORD: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(word_done)); // R4
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        overrun && $past(overrun) |-> $stable(hold)); // R8
    AST_READ_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        rd && !word_done |=> !ready); // R10
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> !overrun); // R9

endmodule

// File: rtl/ssr_slave_rx.sv
module ssr_slave_rx
    import ssr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_sync_en,
    input  logic              cfg_port_en,
    input  logic              cfg_clk_master,
    input  logic              cfg_cont_rx,
    input  logic              cfg_single_rx,
    input  logic              cfg_nine_bit,
    input  logic              cfg_irq_en,
    input  logic              sck_in,
    input  logic              sdat_in,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_ready,
    output logic              rx_overrun,
    output logic              rx_irq
);
    rx_cfg_t  cfg;
    logic     run;
    logic     fall;
    logic     dat_s;
    logic     done;
    rx_word_t word;
    rx_word_t hold;

    always_comb begin
        cfg.sync_en    = cfg_sync_en;
        cfg.port_en    = cfg_port_en;
        cfg.clk_master = cfg_clk_master;
        cfg.cont_rx    = cfg_cont_rx;
        cfg.single_rx  = cfg_single_rx;
        cfg.nine_bit   = cfg_nine_bit;
        cfg.irq_en     = cfg_irq_en;
    end

    assign run = rx_running(cfg);

    ssr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck_raw  (sck_in),
        .dat_raw  (sdat_in),
        .sck_fall (fall),
        .dat_sync (dat_s)
    );

    ssr_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .nine_bit  (cfg.nine_bit),
        .bit_stb   (fall),
        .bit_val   (dat_s),
        .word_done (done),
        .word_out  (word)
    );

    ssr_holding u_hold (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .irq_en    (cfg.irq_en),
        .word_done (done),
        .word_in   (word),
        .rd        (rd_strobe),
        .hold      (hold),
        .ready     (rx_ready),
        .overrun   (rx_overrun),
        .irq       (rx_irq)
    );

    assign rx_data = hold.data;
    assign rx_bit9 = hold.bit9;

    AST_MASTER_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        cfg_clk_master && $past(cfg_clk_master) |-> !done); // R1
    AST_PORT_GATE: assert property (@(posedge clk) disable iff (rst)
        !(cfg_sync_en && cfg_port_en) && $past(!(cfg_sync_en && cfg_port_en)) |-> !done); // R7

endmodule

// File: tb/sim_ssr_slave_rx.sv
module sim_ssr_slave_rx;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_sync_en, cfg_port_en, cfg_clk_master, cfg_cont_rx;
    logic       cfg_single_rx, cfg_nine_bit, cfg_irq_en;
    logic       sck_in, sdat_in;
    logic       rd_mon, rd_man, rd_strobe;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_ready, rx_overrun, rx_irq;

    int checks = 0;
    int fails  = 0;
    bit auto_rd = 1'b0;
    bit finished = 1'b0;
    logic [8:0] exp_q[$];

    always #2 clk = ~clk;
    assign rd_strobe = rd_mon | rd_man;

    ssr_slave_rx u0 (
        .clk(clk), .rst(rst),
        .cfg_sync_en(cfg_sync_en), .cfg_port_en(cfg_port_en),
        .cfg_clk_master(cfg_clk_master), .cfg_cont_rx(cfg_cont_rx),
        .cfg_single_rx(cfg_single_rx), .cfg_nine_bit(cfg_nine_bit),
        .cfg_irq_en(cfg_irq_en), .sck_in(sck_in), .sdat_in(sdat_in),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .rx_ready(rx_ready), .rx_overrun(rx_overrun), .rx_irq(rx_irq)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a word is ready and auto reads are on.
    initial rd_mon = 1'b0;
    always @(negedge clk) begin
        rd_mon <= 1'b0;
        if (auto_rd && rx_ready && !rd_mon) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected word", {rx_bit9, rx_data}, 9'h1ff);
            end else begin
                check("R3/R4/R6 scoreboard word", {rx_bit9, rx_data}, exp_q.pop_front());
            end
            rd_mon <= 1'b1;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: shifts a word LSB first, optionally pushing it as expected.
    task automatic send_word(input logic [8:0] w, input int nbits, input bit push);
        if (push) exp_q.push_back((nbits == 9) ? w : {1'b0, w[7:0]});
        for (int b = 0; b < nbits; b++) begin
            sdat_in = w[b];
            wait_clk(5);
            sck_in = 1'b0;
            wait_clk(5);
            sck_in = 1'b1;
        end
        wait_clk(12);
    endtask

    task automatic read_once();
        rd_man = 1'b1;
        wait_clk(1);
        rd_man = 1'b0;
        wait_clk(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rd_man = 1'b0;
        cfg_sync_en = 1; cfg_port_en = 1; cfg_clk_master = 0; cfg_cont_rx = 1;
        cfg_single_rx = 0; cfg_nine_bit = 0; cfg_irq_en = 0;
        sck_in = 1; sdat_in = 0;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        check("R4 reset ready", {8'd0, rx_ready}, 9'd0);
        check("R8 reset overrun", {8'd0, rx_overrun}, 9'd0);
        check("R5 reset irq", {8'd0, rx_irq}, 9'd0);

        // R3 R4: 8-bit words under several patterns
        auto_rd = 1;
        send_word(9'h0A5, 8, 1);
        send_word(9'h001, 8, 1);
        send_word(9'h080, 8, 1);
        send_word(9'h0FF, 8, 1);
        send_word(9'h000, 8, 1);
        // R6: 9-bit words, then back to 8-bit with ninth bit reading 0
        cfg_nine_bit = 1;
        send_word(9'h13C, 9, 1);
        send_word(9'h0C3, 9, 1);
        send_word(9'h100, 9, 1);
        cfg_nine_bit = 0;
        send_word(9'h15A, 8, 1);
        check("R4 queue drained", 9'(exp_q.size()), 9'd0);

        // R2: continuous receive off, single receive on
        cfg_cont_rx = 0; cfg_single_rx = 1;
        send_word(9'h055, 8, 0);
        check("R2 no word with single receive only", {8'd0, rx_ready}, 9'd0);
        cfg_single_rx = 0; cfg_cont_rx = 1;
        // R1: internal clock source selected
        cfg_clk_master = 1;
        send_word(9'h033, 8, 0);
        check("R1 no word with internal clock", {8'd0, rx_ready}, 9'd0);
        cfg_clk_master = 0;
        // R7: port or sync disabled
        cfg_port_en = 0;
        send_word(9'h0E1, 8, 0);
        check("R7 no word with port off", {8'd0, rx_ready}, 9'd0);
        cfg_port_en = 1; cfg_sync_en = 0;
        send_word(9'h01E, 8, 0);
        check("R7 no word with sync off", {8'd0, rx_ready}, 9'd0);
        cfg_sync_en = 1;
        send_word(9'h0B7, 8, 1);
        check("R7 reception resumes", 9'(exp_q.size()), 9'd0);

        // R5, R10 with manual reads
        auto_rd = 0;
        send_word(9'h06D, 8, 0);
        check("R4 ready after word", {8'd0, rx_ready}, 9'd1);
        check("R5 irq gated off", {8'd0, rx_irq}, 9'd0);
        cfg_irq_en = 1;
        wait_clk(1);
        check("R5 irq with enable", {8'd0, rx_irq}, 9'd1);
        check("R3 data", {1'b0, rx_data}, 9'h06D);

        // R8 overrun: second word without read
        send_word(9'h092, 8, 0);
        check("R8 overrun set", {8'd0, rx_overrun}, 9'd1);
        check("R8 old word kept", {1'b0, rx_data}, 9'h06D);
        read_once();
        check("R10 read clears ready", {8'd0, rx_ready}, 9'd0);
        check("R5 irq drops with ready", {8'd0, rx_irq}, 9'd0);
        send_word(9'h044, 8, 0);
        check("R8 blocked while overrun", {8'd0, rx_ready}, 9'd0);
        check("R8 data unchanged while blocked", {1'b0, rx_data}, 9'h06D);

        // R9 error clear
        cfg_cont_rx = 0;
        wait_clk(2);
        check("R9 overrun cleared", {8'd0, rx_overrun}, 9'd0);
        cfg_cont_rx = 1;
        wait_clk(2);
        send_word(9'h0C8, 8, 0);
        check("R9 reception after clear", {7'd0, rx_ready, rx_overrun}, 9'd2);
        check("R9 new data", {1'b0, rx_data}, 9'h0C8);
        read_once();

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule